// File: doc/BRIEF.md
# Conditional Sum Adder

A combinational unsigned adder for two operands and a carry-in. It gives a sum of the same width and a carry-out. It is meant to be the accumulate adder inside a shift-and-add sequential multiplier, where its delay sets the clock period.

The adder does not ripple a carry through its bit positions. Every single bit first produces two candidate results: a (sum, carry) pair that assumes no incoming carry, and a second pair that assumes an incoming carry of one. Adjacent groups are then merged, and the group size doubles at each level. In each merge, the lower half's two carry-outs pick between the upper half's candidate pairs. After log2(WIDTH) levels, one pair of full-width candidates is left. The external carry-in picks one of them as the result.

Top module: `cond_sum_adder`

## Requirements
- R1: For every pair of WIDTH-bit unsigned operands and either carry-in value, {cout_o, sum_o} equals a_i + b_i + cin_i evaluated at WIDTH+1 bits.
- R2: With both operands all ones and cin_i = 1, sum_o is all ones and cout_o is 1.
- R3: For fixed operands, the (WIDTH+1)-bit value {cout_o, sum_o} with cin_i = 1 is exactly one more, modulo 2^(WIDTH+1), than the value with cin_i = 0. The two full-width candidate sets inside the block also differ by exactly one.
- R4: A carry born at bit 0 reaches the most significant position across every group boundary. With a_i all ones, b_i = 0 and cin_i = 1, sum_o is 0 and cout_o is 1. With a_i = 1 and b_i all ones, sum_o is 0 and cout_o is 1.
- R5: With both operands zero, sum_o equals cin_i zero-extended, and cout_o is 0. The no-carry candidate carry-out never exceeds the with-carry candidate carry-out.
- R6: WIDTH is a parameter. It must be a power of two of at least 2, and the merge tree has log2(WIDTH) levels (5 at the default of 32). A build with WIDTH = 8 meets R1 over its whole operand range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Incoming carry |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the most significant bit |

## Verification
A fixed table of operand pairs targets carry chains of different lengths. Some chains end exactly at a group boundary of each merge level, which separates a wrong lower-carry select from a correct one. All-ones and single-bit-propagate operands force the longest chain through every level, with and without a carry-in, so the final carry-in select and the top carry are exercised. Pseudo-random 32-bit operands and a near-exhaustive sweep of an 8-bit build cover the swapped or mis-indexed multiplexer legs that the directed cases miss. Applying each operand pair with both carry-in values checks that the two selected results differ by one.

// File: rtl/csa_pkg.sv
package csa_pkg;

  function automatic bit csa_is_pow2(input int w);
    return (w >= 2) && ((w & (w - 1)) == 0);
  endfunction

  // merge levels needed to fold WIDTH single bits into one group
  function automatic int csa_levels(input int w);
    int n;
    n = 0;
    while ((1 << n) < w) n++;
    return n;
  endfunction

endpackage

// File: rtl/csa_bit_pairs.sv
module csa_bit_pairs #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] s0_o,
  output logic [WIDTH-1:0] s1_o,
  output logic [WIDTH-1:0] c0_o,
  output logic [WIDTH-1:0] c1_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic x;
    assign x       = a_i[i] ^ b_i[i];
    assign s0_o[i] = x;
    assign c0_o[i] = a_i[i] & b_i[i];
    assign s1_o[i] = ~x;
    assign c1_o[i] = a_i[i] | b_i[i];
  end

endmodule

// File: rtl/csa_merge_level.sv
module csa_merge_level #(
  parameter int WIDTH = 32,
  parameter int GRP   = 1
) (
  input  logic [WIDTH-1:0]            s0_i,
  input  logic [WIDTH-1:0]            s1_i,
  input  logic [WIDTH/GRP-1:0]        c0_i,
  input  logic [WIDTH/GRP-1:0]        c1_i,
  output logic [WIDTH-1:0]            s0_o,
  output logic [WIDTH-1:0]            s1_o,
  output logic [WIDTH/(2*GRP)-1:0]    c0_o,
  output logic [WIDTH/(2*GRP)-1:0]    c1_o
);

  localparam int NOUT = WIDTH / (2 * GRP);

  for (genvar k = 0; k < NOUT; k++) begin : g_pair
    localparam int LO = 2 * k * GRP;
    localparam int HI = LO + GRP;
    logic sel0, sel1;
    assign sel0 = c0_i[2*k];
    assign sel1 = c1_i[2*k];

    // lower half passes through under its own assumption
    assign s0_o[LO +: GRP] = s0_i[LO +: GRP];
    assign s1_o[LO +: GRP] = s1_i[LO +: GRP];

    // upper half picked by lower carry under the same assumption
    assign s0_o[HI +: GRP] = sel0 ? s1_i[HI +: GRP] : s0_i[HI +: GRP];
    assign s1_o[HI +: GRP] = sel1 ? s1_i[HI +: GRP] : s0_i[HI +: GRP];
    assign c0_o[k]         = sel0 ? c1_i[2*k+1] : c0_i[2*k+1];
    assign c1_o[k]         = sel1 ? c1_i[2*k+1] : c0_i[2*k+1];
  end

endmodule

// File: rtl/csa_carry_select.sv
module csa_carry_select #(
  parameter int WIDTH = 32
) (
  input  logic             cin_i,
  input  logic [WIDTH-1:0] s0_i,
  input  logic [WIDTH-1:0] s1_i,
  input  logic             c0_i,
  input  logic             c1_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  assign sum_o  = cin_i ? s1_i : s0_i;
  assign cout_o = cin_i ? c1_i : c0_i;

endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int LEVELS = csa_pkg::csa_levels(WIDTH);

  if (!csa_pkg::csa_is_pow2(WIDTH)) begin : g_bad_width
    $error("cond_sum_adder: WIDTH must be a power of two >= 2");
  end

  logic [WIDTH-1:0] bit_s0, bit_s1, bit_c0, bit_c1;
  logic [WIDTH-1:0] top_s0, top_s1;
  logic             top_c0, top_c1;

  csa_bit_pairs #(.WIDTH(WIDTH)) i_bits (
    .a_i  (a_i),
    .b_i  (b_i),
    .s0_o (bit_s0),
    .s1_o (bit_s1),
    .c0_o (bit_c0),
    .c1_o (bit_c1)
  );

  for (genvar i = 0; i < LEVELS; i++) begin : g_lvl
    localparam int NIN  = WIDTH >> i;
    localparam int NOUT = NIN / 2;
    logic [WIDTH-1:0] in_s0, in_s1, s0, s1;
    logic [NIN-1:0]   in_c0, in_c1;
    logic [NOUT-1:0]  c0, c1;

    if (i == 0) begin : g_src
      assign in_s0 = bit_s0;
      assign in_s1 = bit_s1;
      assign in_c0 = bit_c0;
      assign in_c1 = bit_c1;
    end else begin : g_src
      assign in_s0 = g_lvl[i-1].s0;
      assign in_s1 = g_lvl[i-1].s1;
      assign in_c0 = g_lvl[i-1].c0;
      assign in_c1 = g_lvl[i-1].c1;
    end

    csa_merge_level #(.WIDTH(WIDTH), .GRP(1 << i)) i_merge (
      .s0_i (in_s0),
      .s1_i (in_s1),
      .c0_i (in_c0),
      .c1_i (in_c1),
      .s0_o (s0),
      .s1_o (s1),
      .c0_o (c0),
      .c1_o (c1)
    );
  end

  assign top_s0 = g_lvl[LEVELS-1].s0;
  assign top_s1 = g_lvl[LEVELS-1].s1;
  assign top_c0 = g_lvl[LEVELS-1].c0[0];
  assign top_c1 = g_lvl[LEVELS-1].c1[0];

  csa_carry_select #(.WIDTH(WIDTH)) i_sel (
    .cin_i  (cin_i),
    .s0_i   (top_s0),
    .s1_i   (top_s1),
    .c0_i   (top_c0),
    .c1_i   (top_c1),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );

endmodule

// File: rtl/cond_sum_adder_chk.sv
module cond_sum_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH-1:0] top_s0,
  input logic [WIDTH-1:0] top_s1,
  input logic             top_c0,
  input logic             top_c1
);

  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    AST_SUM_MATCH: assert ({cout_o, sum_o} == ref_sum)
      else $error("sum mismatch"); // R1
    AST_ALL_ONES: assert (!((&a_i) && (&b_i) && cin_i) || ((&sum_o) && cout_o))
      else $error("all-ones case wrong"); // R2
    AST_SET_STEP: assert ({top_c1, top_s1} == {top_c0, top_s0} + {{WIDTH{1'b0}}, 1'b1})
      else $error("candidate sets not one apart"); // R3
    AST_FULL_PROP: assert (!((&a_i) && (b_i == '0) && cin_i) || ((sum_o == '0) && cout_o))
      else $error("full propagate lost"); // R4
    AST_ZERO_OPS: assert (!((a_i == '0) && (b_i == '0)) ||
                          ((sum_o == {{(WIDTH-1){1'b0}}, cin_i}) && !cout_o))
      else $error("zero operand case wrong"); // R5
    AST_CARRY_ORDER: assert (!top_c0 || top_c1)
      else $error("carry candidates out of order"); // R5
  end

endmodule

bind cond_sum_adder cond_sum_adder_chk #(.WIDTH(WIDTH)) i_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .top_s0 (top_s0),
  .top_s1 (top_s1),
  .top_c0 (top_c0),
  .top_c1 (top_c1)
);

// File: tb/test_cond_sum_adder.sv
module test_cond_sum_adder;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] a, b;
  logic        cin;
  logic [31:0] sum;
  logic        cout;

  logic [7:0]  a8, b8;
  logic        cin8;
  logic [7:0]  sum8;
  logic        cout8;

  cond_sum_adder #(.WIDTH(32)) i_cond_sum_adder (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  cond_sum_adder #(.WIDTH(8)) i_cond_sum_adder_w8 (
    .a_i(a8), .b_i(b8), .cin_i(cin8), .sum_o(sum8), .cout_o(cout8)
  );

  // {a, b, cin}
  localparam int NVEC = 14;
  localparam logic [64:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0000_0000, 1'b0},
    {32'h0000_0001, 32'h0000_0001, 1'b0},
    {32'h0000_0001, 32'h0000_0001, 1'b1},
    {32'h0000_000F, 32'h0000_0001, 1'b0},
    {32'h0000_00FF, 32'h0000_0001, 1'b0},
    {32'h0000_FFFF, 32'h0000_0000, 1'b1},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0},
    {32'h8000_0000, 32'h8000_0000, 1'b0},
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b1},
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b0},
    {32'h1234_5678, 32'h9ABC_DEF0, 1'b1},
    {32'hFFFF_0000, 32'h0001_0000, 1'b0},
    {32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1},
    {32'h00FF_FF00, 32'h0000_0100, 1'b0}
  };

  task automatic check32(input string tag, input logic [32:0] exp);
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cin=%0d got %h expected %h", tag, a, b, cin,
               {cout, sum}, exp);
    end
  endtask

  task automatic apply32(input logic [31:0] av, input logic [31:0] bv, input logic cv);
    @(negedge clk);
    a = av; b = bv; cin = cv;
    #2;
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    a8 = '0; b8 = '0; cin8 = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // idle state, zero operands (R5)
    #2;
    check32("R5 idle zero", 33'h0);
    apply32(32'h0, 32'h0, 1'b1);
    check32("R5 zero cin1", 33'h1);

    // table walk (R1)
    for (int i = 0; i < NVEC; i++) begin
      apply32(VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
      check32("R1 table", {1'b0, VEC[i][64:33]} + {1'b0, VEC[i][32:1]} + 33'(VEC[i][0]));
    end

    // all ones (R2)
    apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    check32("R2 all ones cin1", {1'b1, 32'hFFFF_FFFF});
    apply32(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    check32("R2 all ones cin0", {1'b1, 32'hFFFF_FFFE});

    // full-length propagate (R4)
    apply32(32'hFFFF_FFFF, 32'h0, 1'b1);
    check32("R4 ones plus cin", {1'b1, 32'h0});
    apply32(32'h1, 32'hFFFF_FFFF, 1'b0);
    check32("R4 one plus ones", {1'b1, 32'h0});
    apply32(32'hFFFF_FFFF, 32'h0, 1'b0);
    check32("R4 ones no cin", {1'b0, 32'hFFFF_FFFF});

    // carry-in step of one (R3)
    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      logic [32:0] r0, r1;
      ra = (i < NVEC) ? VEC[i][64:33] : $urandom;
      rb = (i < NVEC) ? VEC[i][32:1]  : $urandom;
      apply32(ra, rb, 1'b0);
      r0 = {cout, sum};
      apply32(ra, rb, 1'b1);
      r1 = {cout, sum};
      n_chk++;
      if (r1 !== r0 + 33'd1) begin
        n_fail++;
        $display("FAIL R3: a=%h b=%h got %h expected %h", ra, rb, r1, r0 + 33'd1);
      end
    end

    // random operands (R1)
    for (int i = 0; i < 1000; i++) begin
      logic [31:0] ra, rb;
      logic        rc;
      ra = $urandom; rb = $urandom; rc = 1'($urandom);
      apply32(ra, rb, rc);
      check32("R1 random", {1'b0, ra} + {1'b0, rb} + 33'(rc));
    end

    // 8-bit build sweep (R6)
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib += 5) begin
        for (int ic = 0; ic < 2; ic++) begin
          logic [8:0] exp8;
          a8 = 8'(ia); b8 = 8'(ib); cin8 = 1'(ic);
          #1;
          exp8 = 9'(ia) + 9'(ib) + 9'(ic);
          n_chk++;
          if ({cout8, sum8} !== exp8) begin
            n_fail++;
            $display("FAIL R6: a=%h b=%h cin=%0d got %h expected %h", a8, b8, cin8,
                     {cout8, sum8}, exp8);
          end
        end
      end
    end
    a8 = 8'hFF; b8 = 8'h00; cin8 = 1'b1;
    #1;
    n_chk++;
    if ({cout8, sum8} !== 9'h100) begin
      n_fail++;
      $display("FAIL R6: 8-bit propagate got %h expected %h", {cout8, sum8}, 9'h100);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule